// File: doc/BRIEF.md
# Unit-Cost Counter and Best-Cover Controller

This block sits beside the array of search cells in a branch-and-bound solver for minimum-cost covering. Each cell reports its variable as 0, 1 or unassigned. The block counts the variables that are set to 1, which is the unit cost of the current partial assignment. It compares that count against a bound taken from the cheapest complete cover found so far. When the current path can no longer beat that cover, it raises a cost-exceeded flag so that the array backtracks.

When the formula checker reports that the current assignment satisfies the formula, and the count is lower than the best cost on record, the block captures that cost together with the set of variables at 1. A start pulse opens a search. It clears the record and lets the array run. When the array reports that it has explored the whole space, the block ends the search and holds the record stable for readout.

The bound is the best cost minus one. No estimate is made for the variables still unassigned. The count comes from a balanced tree of adders.

Top module: `cover_cost_ctrl`

## Requirements
- R1: After reset, `best_cost_o` is all ones (CW bits, with CW = clog2(N+2)), `best_assign_o` is 0, and `found_o`, `done_o` and `search_run_o` are all 0.
- R2: `cur_cost_o` equals the number of variable fields in `assign_i` that hold 2'b01. Field k is bits [2k+1:2k]. The code 2'b00 means 0 and the codes 2'b10 and 2'b11 mean unassigned; all of these count 0. The count follows `assign_i` combinationally.
- R3: While a search is running, `cost_exceeded_o` is 1 exactly when the current cost is greater than the bound, the bound being the best cost minus 1. This is the same as the cost not being below the best cost, so a best cost of 0 makes the flag 1 for every assignment.
- R4: While no search is running (idle or done), `cost_exceeded_o` is 0.
- R5: While running, if `formula_i` is 2'b01 (satisfied) and the current cost is below `best_cost_o`, then on the next clock edge `best_cost_o` takes the cost, bit k of `best_assign_o` becomes 1 exactly when field k is 2'b01, and `found_o` becomes 1. All three change on the same edge.
- R6: No capture happens when the cost equals or exceeds `best_cost_o`, or when `formula_i` is 2'b00 (unsatisfied) or 2'b1x (undecided).
- R7: A `start_i` pulse in any state makes `search_run_o` 1 on the next edge. On the same edge it restores `best_cost_o` to all ones and clears `best_assign_o` and `found_o`.
- R8: `search_done_i` during a run makes `done_o` 1 and `search_run_o` 0 on the next edge. From then until the next start, `best_cost_o`, `best_assign_o` and `found_o` do not change, whatever the inputs are.
- R9: When `start_i` is high, it takes priority over a capture and over `search_done_i` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new search; clears the record |
| search_done_i | input | 1 | Search array has exhausted the space |
| assign_i | input | 2*N | Per-variable code: 00 = 0, 01 = 1, 1x = unassigned |
| formula_i | input | 2 | Formula status: 00 = unsatisfied, 01 = satisfied, 1x = undecided |
| cost_exceeded_o | output | 1 | Current path cannot beat the best cover |
| cur_cost_o | output | CW | Number of variables currently at 1 |
| best_cost_o | output | CW | Lowest cover cost found (all ones if none) |
| best_assign_o | output | N | Variables at 1 in the best cover |
| found_o | output | 1 | At least one cover captured this search |
| search_run_o | output | 1 | Search array may run |
| done_o | output | 1 | Search finished; record is held |

## Verification
On every cycle, the assertions check the following. The adder tree must agree with a plain bit count. The best cost must never rise during a run. The flag must imply a cost no lower than the record and must stay low outside a run. The stored cost must always equal the number of ones in the stored assignment. The record must stay unchanged after completion. Only the bench's scenarios can show the rest: that the cost and flag are correct over every code of a four-variable configuration, that a tie, an unsatisfied status or an undecided status does not capture, that start wins over a simultaneous capture and over completion, and that a zero-cost cover forces the flag high for every assignment.

// File: rtl/cover_cost_pkg.sv
package cover_cost_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_RUN  = 2'd1,
    CTL_DONE = 2'd2
  } ctl_state_t;

  localparam logic [1:0] VAR_ZERO = 2'b00;
  localparam logic [1:0] VAR_ONE  = 2'b01;
  localparam logic [1:0] FRM_SAT  = 2'b01;

  // A variable contributes to the cost only when it is firmly at one.
  function automatic logic var_is_one(input logic [1:0] code);
    return code == VAR_ONE;
  endfunction

  function automatic logic formula_sat(input logic [1:0] code);
    return code == FRM_SAT;
  endfunction

endpackage

// File: rtl/cover_popcount_tree.sv
module cover_popcount_tree #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ones_i,
  output logic [CW-1:0] sum_o
);

  localparam int LVLS = (N > 1) ? $clog2(N) : 1;
  localparam int P    = 1 << LVLS;

  // Heap layout: node 1 is the root, nodes P..2P-1 are the leaves.
  logic [CW-1:0] node [1:2*P-1];

  for (genvar g = 0; g < P; g++) begin : g_leaf
    if (g < N) begin : g_real
      assign node[P+g] = {{(CW-1){1'b0}}, ones_i[g]};
    end else begin : g_pad
      assign node[P+g] = '0;
    end
  end

  for (genvar i = 1; i < P; i++) begin : g_add
    assign node[i] = node[2*i] + node[2*i+1];
  end

  assign sum_o = node[1];

  // R2: the tree agrees with a flat bit count
  assert_tree_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sum_o == CW'($countones(ones_i)));

endmodule

// File: rtl/cover_bound_unit.sv
module cover_bound_unit #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [CW-1:0] cost_i,
  input  logic [CW-1:0] best_i,
  output logic          exceeded_o
);

  logic [CW-1:0] bound;
  logic          bound_neg;

  // Bound is one below the best cover; a zero best leaves no room at all.
  function automatic logic over_bound(input logic [CW-1:0] cost,
                                      input logic [CW-1:0] bnd,
                                      input logic          neg);
    return neg || (cost > bnd);
  endfunction

  assign bound      = best_i - CW'(1);
  assign bound_neg  = (best_i == '0);
  assign exceeded_o = run_i && over_bound(cost_i, bound, bound_neg);

  // R3: a raised flag means the path cannot undercut the record
  assert_flag_means_no_gain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exceeded_o |-> (cost_i >= best_i));

  // R3: a path strictly cheaper than the record is never pruned
  assert_cheaper_not_pruned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cost_i < best_i) |-> !exceeded_o);

  // R4: flag silent outside a run
  assert_flag_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !exceeded_o);

endmodule

// File: rtl/cover_best_store.sv
module cover_best_store #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          cap_i,
  input  logic [CW-1:0] cost_i,
  input  logic [N-1:0]  ones_i,
  output logic [CW-1:0] best_cost_o,
  output logic [N-1:0]  best_assign_o,
  output logic          found_o
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      best_cost_o   <= '1;
      best_assign_o <= '0;
      found_o       <= 1'b0;
    end else if (cap_i) begin
      best_cost_o   <= cost_i;
      best_assign_o <= ones_i;
      found_o       <= 1'b1;
    end
  end

  // R5: a capture loads the offered cost
  assert_capture_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && !clear_i) |=> (best_cost_o == $past(cost_i)) && found_o);

  // R5: stored cost always matches the stored cover
  assert_record_consistent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (best_cost_o == CW'($countones(best_assign_o))));

  // R6: without capture or clear, the record holds
  assert_record_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && !clear_i) |=> $stable(best_cost_o) && $stable(best_assign_o) && $stable(found_o));

  // R7: clear restores the empty record
  assert_clear_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (best_cost_o == '1) && (best_assign_o == '0) && !found_o);

endmodule

// File: rtl/cover_ctl.sv
module cover_ctl
  import cover_cost_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic search_done_i,
  output logic run_o,
  output logic done_o
);

  ctl_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    if (start_i) begin
      state_nx = CTL_RUN;
    end else if (state == CTL_RUN && search_done_i) begin
      state_nx = CTL_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= CTL_IDLE;
    else        state <= state_nx;
  end

  assign run_o  = (state == CTL_RUN);
  assign done_o = (state == CTL_DONE);

  // R8: running and finished are never reported together
  assert_run_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({run_o, done_o}));

  // R9: start always lands in a run
  assert_start_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> run_o);

  // R8: completion ends the run
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && search_done_i && !start_i) |=> done_o);

endmodule

// File: rtl/cover_cost_ctrl.sv
module cover_cost_ctrl
  import cover_cost_pkg::*;
#(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          search_done_i,
  input  logic [2*N-1:0] assign_i,
  input  logic [1:0]    formula_i,
  output logic          cost_exceeded_o,
  output logic [CW-1:0] cur_cost_o,
  output logic [CW-1:0] best_cost_o,
  output logic [N-1:0]  best_assign_o,
  output logic          found_o,
  output logic          search_run_o,
  output logic          done_o
);

  logic [N-1:0] ones_vec;
  logic         run;
  logic         sat_now;
  logic         cheaper;
  logic         cap_event;

  for (genvar k = 0; k < N; k++) begin : g_decode
    assign ones_vec[k] = var_is_one(assign_i[2*k+1:2*k]);
  end

  cover_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .search_done_i (search_done_i),
    .run_o         (run),
    .done_o        (done_o)
  );

  cover_popcount_tree #(.N(N), .CW(CW)) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .ones_i (ones_vec),
    .sum_o  (cur_cost_o)
  );

  cover_bound_unit #(.CW(CW)) u_bound (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .cost_i     (cur_cost_o),
    .best_i     (best_cost_o),
    .exceeded_o (cost_exceeded_o)
  );

  assign sat_now   = formula_sat(formula_i);
  assign cheaper   = (cur_cost_o < best_cost_o);
  assign cap_event = run && !start_i && sat_now && cheaper;

  cover_best_store #(.N(N), .CW(CW)) u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (start_i),
    .cap_i         (cap_event),
    .cost_i        (cur_cost_o),
    .ones_i        (ones_vec),
    .best_cost_o   (best_cost_o),
    .best_assign_o (best_assign_o),
    .found_o       (found_o)
  );

  assign search_run_o = run;

  // R6: during a run the record cost never rises unless restarted
  assert_best_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start_i) |=> (best_cost_o <= $past(best_cost_o)));

  // R8: record frozen while finished
  assert_done_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> $stable(best_cost_o) && $stable(best_assign_o) && done_o);

endmodule

// File: tb/tb_cover_cost_ctrl.sv
module tb_cover_cost_ctrl;

  localparam int N   = 4;
  localparam int CW  = $clog2(N + 2);
  localparam int ALL = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          search_done_i;
  logic [2*N-1:0] assign_i;
  logic [1:0]    formula_i;
  logic          cost_exceeded_o;
  logic [CW-1:0] cur_cost_o;
  logic [CW-1:0] best_cost_o;
  logic [N-1:0]  best_assign_o;
  logic          found_o;
  logic          search_run_o;
  logic          done_o;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  cover_cost_ctrl #(.N(N)) dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .search_done_i   (search_done_i),
    .assign_i        (assign_i),
    .formula_i       (formula_i),
    .cost_exceeded_o (cost_exceeded_o),
    .cur_cost_o      (cur_cost_o),
    .best_cost_o     (best_cost_o),
    .best_assign_o   (best_assign_o),
    .found_o         (found_o),
    .search_run_o    (search_run_o),
    .done_o          (done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cost(input logic [2*N-1:0] a);
    int c = 0;
    for (int k = 0; k < N; k++) if (a[2*k +: 2] == 2'b01) c++;
    return c;
  endfunction

  function automatic int exp_mask(input logic [2*N-1:0] a);
    int m = 0;
    for (int k = 0; k < N; k++) if (a[2*k +: 2] == 2'b01) m |= (1 << k);
    return m;
  endfunction

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // Sweep every code with an undecided formula so nothing is captured.
  task automatic sweep(input int best_now, input bit run_now);
    formula_i = 2'b10;
    for (int code = 0; code < (1 << (2*N)); code++) begin
      assign_i = code[2*N-1:0];
      #1;
      check("R2 cost", int'(cur_cost_o), exp_cost(assign_i));
      if (run_now)
        check("R3 exceeded", int'(cost_exceeded_o), int'(exp_cost(assign_i) >= best_now));
      else
        check("R4 exceeded idle", int'(cost_exceeded_o), 0);
    end
  endtask

  task automatic record(input string req, input int cost, input int mask, input int fnd);
    check({req, " best_cost"}, int'(best_cost_o), cost);
    check({req, " best_assign"}, int'(best_assign_o), mask);
    check({req, " found"}, int'(found_o), fnd);
  endtask

  task automatic offer(input logic [2*N-1:0] a, input logic [1:0] f);
    assign_i  = a;
    formula_i = f;
    tick();
    formula_i = 2'b10;
  endtask

  initial begin
    #(200000 * 20);
    if (!ended) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; search_done_i = 1'b0;
    assign_i = '0; formula_i = 2'b10;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    record("R1", ALL, 0, 0);
    check("R1 done", int'(done_o), 0);
    check("R1 run", int'(search_run_o), 0);

    sweep(ALL, 1'b0);

    // R7 start
    start_i = 1'b1; tick(); start_i = 1'b0;
    check("R7 run", int'(search_run_o), 1);
    record("R7", ALL, 0, 0);
    sweep(ALL, 1'b1);

    // R5 first cover: v1,v2,v3 at one
    offer(8'b01_01_01_00, 2'b01);
    record("R5 first", 3, 4'b1110, 1);

    // R6 tie with a different set: no capture
    offer(8'b10_01_01_01, 2'b01);
    record("R6 tie", 3, 4'b1110, 1);

    // R6 cheaper but unsatisfied / undecided
    offer(8'b00_00_00_01, 2'b00);
    record("R6 unsat", 3, 4'b1110, 1);
    offer(8'b00_00_00_01, 2'b11);
    record("R6 undecided", 3, 4'b1110, 1);

    // R6 more expensive cover
    offer(8'b01_01_01_01, 2'b01);
    record("R6 dearer", 3, 4'b1110, 1);

    sweep(3, 1'b1);

    // R5 cheaper cover
    offer(8'b11_10_01_00, 2'b01);
    record("R5 cheaper", 1, 4'b0010, 1);

    // R8 completion
    search_done_i = 1'b1; tick(); search_done_i = 1'b0;
    check("R8 done", int'(done_o), 1);
    check("R8 run", int'(search_run_o), 0);
    offer(8'b00_00_00_00, 2'b01);
    record("R8 hold", 1, 4'b0010, 1);
    check("R8 still done", int'(done_o), 1);
    sweep(1, 1'b0);

    // R9 start beats a simultaneous capture
    assign_i = 8'b00_00_00_00; formula_i = 2'b01; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    record("R9 start over capture", ALL, 0, 0);
    check("R9 run", int'(search_run_o), 1);
    check("R9 done", int'(done_o), 0);

    // R5 zero-cost cover, then R3 corner: flag always high
    tick();
    formula_i = 2'b10;
    record("R5 zero", 0, 0, 1);
    sweep(0, 1'b1);

    // R9 start beats search_done
    start_i = 1'b1; search_done_i = 1'b1; tick();
    start_i = 1'b0; search_done_i = 1'b0;
    check("R9 run over done", int'(search_run_o), 1);
    check("R9 no done", int'(done_o), 0);
    record("R9 cleared", ALL, 0, 0);

    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule